// File: doc/BRIEF.md
# Iterative Carry-Ripple Accumulator Adder

This block adds an operand to, or subtracts it from, an accumulator value without a full-width carry chain. It keeps two registers. The accumulator register holds the partial sum. The pending register holds carries, or borrows when subtracting, that are not yet absorbed. Each clock step folds the pending bits into the partial sum with an exclusive-or. The new carries are moved up one bit position. The operation ends on the first cycle in which the pending register holds no set bit. The number of cycles therefore depends on the data: zero steps for a zero operand, and up to one step per bit when a carry must travel the full width.

A sequencer raises `start_i` together with an initial accumulator value, an operand and an add/subtract select. While the pending register is nonzero, `busy_o` stays high. The surrounding timing chain uses this level to hold its last timing state and extend it. A one-cycle `done_o` pulse tells the sequencer it may move on. A carry or borrow that leaves the top bit is dropped from the pending register and recorded in a sticky flag.

Top module: `ripple_accum_adder`

## Requirements
- R1: While `rst_ni` is low, the following are all zero: the accumulator, the pending register, `busy_o`, `done_o` and `carry_o`.
- R2: When `start_i` is high and `busy_o` is low, the next clock edge does four things: it loads the accumulator from `a_init_i`, loads the pending register from `operand_i`, latches `sub_i` (1 = subtract, 0 = add) and clears `carry_o`.
- R3: In an add operation, each busy cycle updates the accumulator to (acc xor pend) and the pending register to ((acc and pend) shifted left by one, with bit 0 filled with 0).
- R4: In a subtract operation, each busy cycle updates the accumulator to (acc xor pend) and the pending register to (((not acc) and pend) shifted left by one, with bit 0 filled with 0).
- R5: `busy_o` is high exactly when an operation is in progress and the pending register is nonzero. It never falls without `done_o` being high in the following cycle.
- R6: `done_o` is a single-cycle pulse. It is high in the first cycle after a load in which the pending register is zero. A zero operand gives `done_o` in the cycle right after the load, with no busy cycle.
- R7: At `done_o`, the accumulator equals (a_init + operand) mod 2^WIDTH for an add, and (a_init - operand) mod 2^WIDTH for a subtract.
- R8: `carry_o` is set when a step drops a set bit out of the most significant position. At `done_o` it equals the carry out of the add, or the borrow of the subtract (a_init < operand). It stays set until the next load.
- R9: `start_i` is ignored while `busy_o` is high. The running operation, its mode and its result are unchanged.
- R10: An operation has at most WIDTH busy cycles.
- R11: Adding 0x0001 to 0x7FFF leaves pending = 0x0002 and accumulator = 0x7FFE after the first step. The operation then takes 16 busy cycles in total and ends with accumulator 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load request, taken when not busy |
| sub_i | input | 1 | 1 selects subtract, 0 selects add |
| a_init_i | input | WIDTH | Initial accumulator value |
| operand_i | input | WIDTH | Operand loaded into the pending register |
| acc_o | output | WIDTH | Accumulator (partial sum) |
| pend_o | output | WIDTH | Pending carries or borrows |
| busy_o | output | 1 | Operation still rippling; holds the timing chain |
| done_o | output | 1 | One-cycle completion pulse |
| carry_o | output | 1 | Sticky carry-out or borrow flag |

## Verification
The bench builds the block at the default WIDTH of 16. This makes the longest ripple, 0x7FFF plus 1 taking 16 steps, reachable and exactly checkable. The same width brings both wrap edges into play: 0xFFFF plus 1 sets the carry, and 0 minus 1 sets the borrow. Random operands of both modes have every step checked against the update rule and every final value checked against modular arithmetic. Start pulses injected in the middle of an operation show that the load gate holds.

// File: rtl/ripple_accum_pkg.sv
package ripple_accum_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } acc_op_e;
endpackage

// File: rtl/ripple_step.sv
module ripple_step
  import ripple_accum_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] pend_i,
  input  acc_op_e          op_i,
  output logic [WIDTH-1:0] acc_nxt_o,
  output logic [WIDTH-1:0] pend_nxt_o,
  output logic             drop_o
);
  logic [WIDTH-1:0] gen;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // borrow generates where acc bit is 0, carry where it is 1
    assign acc_nxt_o[i] = acc_i[i] ^ pend_i[i];
    assign gen[i]       = ((op_i == OP_SUB) ? ~acc_i[i] : acc_i[i]) & pend_i[i];
  end

  if (WIDTH > 1) begin : g_shift
    assign pend_nxt_o = {gen[WIDTH-2:0], 1'b0};
  end else begin : g_single
    assign pend_nxt_o = '0;
  end

  assign drop_o = gen[WIDTH-1];
endmodule

// File: rtl/ripple_ctrl.sv
module ripple_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic pend_zero_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  logic active_q;

  assign busy_o = active_q & ~pend_zero_i;
  assign done_o = active_q & pend_zero_i;
  assign load_o = start_i & ~busy_o;
  assign step_o = busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_q <= 1'b0;
    else if (load_o) active_q <= 1'b1;
    else if (done_o) active_q <= 1'b0;
  end

  // R6: done lasts one cycle unless a fresh load follows at once
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o || $past(start_i)));

  // R5: busy only ends through done
  a_r5_busy_ends_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));
endmodule

// File: rtl/ripple_accum_adder.sv
module ripple_accum_adder
  import ripple_accum_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sub_i,
  input  logic [WIDTH-1:0] a_init_i,
  input  logic [WIDTH-1:0] operand_i,
  output logic [WIDTH-1:0] acc_o,
  output logic [WIDTH-1:0] pend_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             carry_o
);
  localparam int CntW = $clog2(WIDTH + 2);

  logic [WIDTH-1:0] acc_q, pend_q, acc_nxt, pend_nxt;
  acc_op_e          op_q;
  logic             carry_q, drop, load, step;

  ripple_step #(.WIDTH(WIDTH)) u_step (
    .acc_i      (acc_q),
    .pend_i     (pend_q),
    .op_i       (op_q),
    .acc_nxt_o  (acc_nxt),
    .pend_nxt_o (pend_nxt),
    .drop_o     (drop)
  );

  ripple_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .pend_zero_i (pend_q == '0),
    .load_o      (load),
    .step_o      (step),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      pend_q  <= '0;
      op_q    <= OP_ADD;
      carry_q <= 1'b0;
    end else if (load) begin
      acc_q   <= a_init_i;
      pend_q  <= operand_i;
      op_q    <= sub_i ? OP_SUB : OP_ADD;
      carry_q <= 1'b0;
    end else if (step) begin
      acc_q   <= acc_nxt;
      pend_q  <= pend_nxt;
      carry_q <= carry_q | drop;
    end
  end

  assign acc_o   = acc_q;
  assign pend_o  = pend_q;
  assign carry_o = carry_q;

  // busy run length, checker only
  logic [CntW-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R10: at most WIDTH busy cycles
  a_r10_bounded_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_q < CntW'(WIDTH)));

  // R3: an add step preserves acc + pend modulo 2^WIDTH
  a_r3_sum_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_q == OP_ADD) |=>
      (WIDTH'(acc_q + pend_q) == WIDTH'($past(acc_q) + $past(pend_q))));

  // R4: a subtract step preserves acc - pend modulo 2^WIDTH
  a_r4_diff_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_q == OP_SUB) |=>
      (WIDTH'(acc_q - pend_q) == WIDTH'($past(acc_q) - $past(pend_q))));

  // R3: after a step the lowest pending bit is clear
  a_r3_pend_lsb_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !pend_q[0]);

  // R8: carry flag sticky until a new load
  a_r8_carry_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_o && !start_i) |=> carry_o);

  // R9: mode holds while busy
  a_r9_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(op_q));
endmodule

// File: tb/ripple_accum_adder_tb_top.sv
module ripple_accum_adder_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         sub_sel = 1'b0;
  logic [W-1:0] a_init = '0;
  logic [W-1:0] opnd = '0;
  logic [W-1:0] acc, pend;
  logic         busy, done, carry;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  ripple_accum_adder #(.WIDTH(W)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .sub_i     (sub_sel),
    .a_init_i  (a_init),
    .operand_i (opnd),
    .acc_o     (acc),
    .pend_o    (pend),
    .busy_o    (busy),
    .done_o    (done),
    .carry_o   (carry)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [W:0] ref_result(input logic [W-1:0] a, input logic [W-1:0] b, input bit s);
    logic [W:0] r;
    if (s) r = {(a < b), W'(a - b)};
    else   r = {1'b0, a} + {1'b0, b};
    return r;
  endfunction

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit s,
                        input bit poke, input int exp_busy);
    logic [W-1:0] pa, pd, g, ea, ed;
    logic [W:0]   r;
    logic         exp_c;
    int           n;
    r = ref_result(a, b, s);
    @(negedge clk);
    start = 1'b1; a_init = a; opnd = b; sub_sel = s;
    @(negedge clk);
    start = 1'b0;
    chk(acc == a, "R2 load acc", acc, a);
    chk(pend == b, "R2 load pend", pend, b);
    chk(carry == 1'b0, "R2 carry cleared", carry, 0);
    n = 0;
    exp_c = 1'b0;
    while (!done) begin
      chk(busy == 1'b1, "R5 busy while pending", busy, 1);
      pa = acc; pd = pend;
      if (poke && n == 1) begin
        start = 1'b1; a_init = ~a; opnd = 16'h0001; sub_sel = ~s;
      end
      @(negedge clk);
      start = 1'b0;
      n++;
      g  = s ? (~pa & pd) : (pa & pd);
      ea = pa ^ pd;
      ed = {g[W-2:0], 1'b0};
      if (g[W-1]) exp_c = 1'b1;
      if (s) begin
        chk(acc == ea, "R4 step acc", acc, ea);
        chk(pend == ed, "R4 step pend", pend, ed);
      end else begin
        chk(acc == ea, "R3 step acc", acc, ea);
        chk(pend == ed, "R3 step pend", pend, ed);
      end
      chk(carry == exp_c, "R8 carry tracks drop", carry, exp_c);
      if (n > W) begin
        chk(1'b0, "R10 run too long", n, W);
        break;
      end
    end
    chk(busy == 1'b0, "R6 not busy at done", busy, 0);
    chk(acc == r[W-1:0], poke ? "R9 result after ignored start" : "R7 final acc", acc, r[W-1:0]);
    chk(carry == r[W], "R8 final carry", carry, r[W]);
    chk(n <= W, "R10 run length", n, W);
    if (b == '0) chk(n == 0, "R6 zero operand no busy", n, 0);
    if (exp_busy >= 0) chk(n == exp_busy, "R11 busy cycles", n, exp_busy);
    @(negedge clk);
    chk(done == 1'b0, "R6 done single pulse", done, 0);
    chk(carry == r[W], "R8 carry held", carry, r[W]);
    chk(acc == r[W-1:0], "R7 acc held", acc, r[W-1:0]);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5EED);
    #5;
    chk(acc == '0 && pend == '0, "R1 reset regs", {acc, pend}, 0);
    chk(!busy && !done && !carry, "R1 reset flags", {busy, done, carry}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R11: first step then full ripple
    @(negedge clk);
    start = 1'b1; a_init = 16'h7FFF; opnd = 16'h0001; sub_sel = 1'b0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(pend == 16'h0002, "R11 pend after first step", pend, 16'h0002);
    chk(acc == 16'h7FFE, "R11 acc after first step", acc, 16'h7FFE);
    while (!done) @(negedge clk);
    chk(acc == 16'h8000, "R11 final acc", acc, 16'h8000);
    @(negedge clk);

    run_op(16'h7FFF, 16'h0001, 1'b0, 1'b0, 16);
    run_op(16'hFFFF, 16'h0001, 1'b0, 1'b0, 16);
    run_op(16'h0000, 16'h0001, 1'b1, 1'b0, -1);
    run_op(16'h1234, 16'h0000, 1'b0, 1'b0, 0);
    run_op(16'h1234, 16'h0000, 1'b1, 1'b0, 0);
    run_op(16'hAAAA, 16'h5555, 1'b0, 1'b0, -1);
    run_op(16'h5555, 16'h5555, 1'b1, 1'b0, -1);
    run_op(16'h7FFF, 16'h0001, 1'b0, 1'b1, -1);
    run_op(16'h8000, 16'h0001, 1'b1, 1'b1, -1);

    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      if (i % 7 == 0) rb = '0;
      run_op(ra, rb, 1'($urandom), (i % 5 == 0), -1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule